// File: doc/BRIEF.md
# Execute-Stage Operand Forwarding Unit

This block sits in the execute stage of a five-stage in-order pipeline and picks the two ALU operands. For each operand it compares the source register number held in the decode/execute pipeline register with the destination register numbers of the instructions now in the memory and writeback stages. When an older instruction that is still in flight is going to write that register, the block takes its result directly instead of the stale register-file value. Back-to-back dependent ALU instructions therefore run without stalls.

Each operand gets a 2-bit select code and a multiplexed data word. The block has no state. Selects and operands settle within the execute cycle from the pipeline-register fields presented at its inputs. If both older stages target the same register, the younger of the two wins. Register zero is never forwarded.

Top module: `fwd_unit`

## Requirements
- R1: When neither older stage qualifies for an operand, its select is 00 and the operand equals the register-file value for that operand.
- R2: The memory-stage path qualifies for an operand when `exm_wen` is 1, `exm_rd` is nonzero and `exm_rd` equals the operand's source field. The select is then 10 and the operand equals `exm_result`.
- R3: The writeback-stage path qualifies for an operand when `mwb_wen` is 1, `mwb_rd` is nonzero and `mwb_rd` equals the operand's source field. If the memory-stage path does not qualify, the select is 01 and the operand equals `mwb_result`.
- R4: When both paths qualify for the same operand, the memory-stage path wins and the select is 10.
- R5: A memory-stage instruction whose destination matches but whose `exm_wen` is 0 does not block a qualifying writeback-stage path.
- R6: A destination of register 0 never causes forwarding, even with its write flag set.
- R7: Operand A is decided only from `id_rs` and operand B only from `id_rt`. When the two fields are equal, both selects and both operands are equal.
- R8: Select code 11 is never produced.
- R9: Each operand output equals the source named by its select code: 00 is the register file, 10 is `exm_result` and 01 is `mwb_result`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs | input | ADDR_W | Source register for operand A (decode/execute register) |
| id_rt | input | ADDR_W | Source register for operand B (decode/execute register) |
| rf_a | input | DATA_W | Register-file read value for operand A |
| rf_b | input | DATA_W | Register-file read value for operand B |
| exm_wen | input | 1 | Register-write flag of the memory-stage instruction |
| exm_rd | input | ADDR_W | Destination register of the memory-stage instruction |
| exm_result | input | DATA_W | ALU result held in the execute/memory register |
| mwb_wen | input | 1 | Register-write flag of the writeback-stage instruction |
| mwb_rd | input | ADDR_W | Destination register of the writeback-stage instruction |
| mwb_result | input | DATA_W | Result held in the memory/writeback register |
| sel_a | output | 2 | Select code for operand A |
| sel_b | output | 2 | Select code for operand B |
| opnd_a | output | DATA_W | Forwarded operand A |
| opnd_b | output | DATA_W | Forwarded operand B |

## Verification
The bench sweeps every combination of both source fields, both destinations and both write flags on a four-register configuration. This reaches the register-zero case, the case where both stages write the same register, and the case where a non-writing memory-stage instruction matches while the writeback stage does write. A unit that let register zero forward would replace a hard-wired zero with a live result. A unit that favoured the writeback stage would feed accumulation chains a value one instruction old. A unit that blocked on a bare destination match would hand the stale register-file value to an instruction whose producer is in writeback. Cases where the two source fields are equal catch cross-coupling between the two operand paths.

// File: rtl/fwd_unit.sv
module fwd_unit #(
  parameter int DATA_W  = 32,
  parameter int REG_CNT = 32,
  localparam int ADDR_W = $clog2(REG_CNT)
) (
  input  logic [ADDR_W-1:0] id_rs,
  input  logic [ADDR_W-1:0] id_rt,
  input  logic [DATA_W-1:0] rf_a,
  input  logic [DATA_W-1:0] rf_b,
  input  logic              exm_wen,
  input  logic [ADDR_W-1:0] exm_rd,
  input  logic [DATA_W-1:0] exm_result,
  input  logic              mwb_wen,
  input  logic [ADDR_W-1:0] mwb_rd,
  input  logic [DATA_W-1:0] mwb_result,
  output logic [1:0]        sel_a,
  output logic [1:0]        sel_b,
  output logic [DATA_W-1:0] opnd_a,
  output logic [DATA_W-1:0] opnd_b
);

  localparam logic [1:0] SEL_RF  = 2'b00;
  localparam logic [1:0] SEL_WB  = 2'b01;
  localparam logic [1:0] SEL_MEM = 2'b10;

  logic exm_live, mwb_live;
  assign exm_live = exm_wen && (exm_rd != '0);
  assign mwb_live = mwb_wen && (mwb_rd != '0);

  function automatic logic [1:0] pick(input logic [ADDR_W-1:0] src);
    if (exm_live && exm_rd == src)      return SEL_MEM;
    else if (mwb_live && mwb_rd == src) return SEL_WB;
    else                                return SEL_RF;
  endfunction

  function automatic logic [DATA_W-1:0] route(input logic [1:0] sel,
                                              input logic [DATA_W-1:0] rf);
    case (sel)
      SEL_MEM: return exm_result;
      SEL_WB:  return mwb_result;
      default: return rf;
    endcase
  endfunction

  assign sel_a  = pick(id_rs);
  assign sel_b  = pick(id_rt);
  assign opnd_a = route(sel_a, rf_a);
  assign opnd_b = route(sel_b, rf_b);

endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk #(
  parameter int DATA_W  = 32,
  parameter int REG_CNT = 32,
  localparam int ADDR_W = $clog2(REG_CNT)
) (
  input logic [ADDR_W-1:0] id_rs,
  input logic [ADDR_W-1:0] id_rt,
  input logic [DATA_W-1:0] rf_a,
  input logic [DATA_W-1:0] rf_b,
  input logic              exm_wen,
  input logic [ADDR_W-1:0] exm_rd,
  input logic [DATA_W-1:0] exm_result,
  input logic              mwb_wen,
  input logic [ADDR_W-1:0] mwb_rd,
  input logic [DATA_W-1:0] mwb_result,
  input logic [1:0]        sel_a,
  input logic [1:0]        sel_b,
  input logic [DATA_W-1:0] opnd_a,
  input logic [DATA_W-1:0] opnd_b
);
  always_comb begin
    p_no_code3_r8: assert (sel_a != 2'b11 && sel_b != 2'b11);
    p_zero_never_r6: assert (!(sel_a == 2'b10 && exm_rd == '0) && !(sel_a == 2'b01 && mwb_rd == '0));
    p_mem_wins_r4: assert (!(sel_a == 2'b01 && exm_wen && exm_rd != '0 && exm_rd == id_rs));
    p_mux_mem_r9: assert (sel_a != 2'b10 || opnd_a == exm_result);
    p_mux_rf_r9: assert (sel_b != 2'b00 || opnd_b == rf_b);
    p_same_src_r7: assert (id_rs != id_rt || sel_a == sel_b);
  end
endmodule

bind fwd_unit fwd_unit_chk #(.DATA_W(DATA_W), .REG_CNT(REG_CNT)) u_chk (
  .id_rs(id_rs), .id_rt(id_rt), .rf_a(rf_a), .rf_b(rf_b),
  .exm_wen(exm_wen), .exm_rd(exm_rd), .exm_result(exm_result),
  .mwb_wen(mwb_wen), .mwb_rd(mwb_rd), .mwb_result(mwb_result),
  .sel_a(sel_a), .sel_b(sel_b), .opnd_a(opnd_a), .opnd_b(opnd_b)
);

// File: tb/sim_fwd_unit.sv
module sim_fwd_unit;
  localparam int DW = 32;
  localparam int RC = 4;
  localparam int AW = $clog2(RC);

  logic clk = 0;
  logic rst_n = 0;
  always #5 clk = ~clk;

  logic [AW-1:0] id_rs, id_rt, exm_rd, mwb_rd;
  logic [DW-1:0] rf_a, rf_b, exm_result, mwb_result, opnd_a, opnd_b;
  logic exm_wen, mwb_wen;
  logic [1:0] sel_a, sel_b;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  fwd_unit #(.DATA_W(DW), .REG_CNT(RC)) u0 (
    .id_rs(id_rs), .id_rt(id_rt), .rf_a(rf_a), .rf_b(rf_b),
    .exm_wen(exm_wen), .exm_rd(exm_rd), .exm_result(exm_result),
    .mwb_wen(mwb_wen), .mwb_rd(mwb_rd), .mwb_result(mwb_result),
    .sel_a(sel_a), .sel_b(sel_b), .opnd_a(opnd_a), .opnd_b(opnd_b)
  );

  function automatic logic [1:0] exp_sel(input int src, input int erd, input int ew,
                                         input int wrd, input int ww);
    if (ew != 0 && erd != 0 && erd == src) return 2'b10;
    if (ww != 0 && wrd != 0 && wrd == src) return 2'b01;
    return 2'b00;
  endfunction

  function automatic string tag(input int src, input int erd, input int ew,
                                input int wrd, input int ww);
    bit e = (ew != 0 && erd != 0 && erd == src);
    bit w = (ww != 0 && wrd != 0 && wrd == src);
    if (src == 0 && ((ew != 0 && erd == 0) || (ww != 0 && wrd == 0))) return "R6";
    if (e && w) return "R4";
    if (w && ew == 0 && erd == src) return "R5";
    if (e) return "R2";
    if (w) return "R3";
    return "R1";
  endfunction

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h (rs=%0d rt=%0d exm=%0d/%0d mwb=%0d/%0d)",
               req, act, exp, id_rs, id_rt, exm_wen, exm_rd, mwb_wen, mwb_rd);
    end
  endtask

  function automatic logic [DW-1:0] exp_op(input logic [1:0] s, input logic [DW-1:0] rf);
    return s == 2'b10 ? exm_result : (s == 2'b01 ? mwb_result : rf);
  endfunction

  initial begin
    id_rs = '0; id_rt = '0; exm_rd = '0; mwb_rd = '0;
    exm_wen = 0; mwb_wen = 0;
    rf_a = 32'h0; rf_b = 32'h0; exm_result = 32'h0; mwb_result = 32'h0;
    repeat (3) @(posedge clk);
    rst_n = 1;
    @(negedge clk); #2;
    // R1: idle state selects the register file
    chk("R1", {30'd0, sel_a}, 32'd0);
    chk("R1", {30'd0, sel_b}, 32'd0);

    // R2: add r1 then sub reading r1 the next cycle sees the new value
    @(negedge clk);
    exm_wen = 1; exm_rd = 1; exm_result = 32'hFFFF_FFEC;
    id_rs = 1; id_rt = 3; rf_a = 32'd10; rf_b = 32'd5;
    #2;
    chk("R2", opnd_a, 32'hFFFF_FFEC);
    chk("R2", opnd_b, 32'd5);

    exm_result = 32'h1111_0000; mwb_result = 32'h2222_0000;
    for (int rs = 0; rs < RC; rs++)
      for (int rt = 0; rt < RC; rt++)
        for (int er = 0; er < RC; er++)
          for (int wr = 0; wr < RC; wr++)
            for (int fl = 0; fl < 4; fl++) begin
              logic [1:0] ea, eb;
              @(negedge clk);
              id_rs = AW'(rs); id_rt = AW'(rt); exm_rd = AW'(er); mwb_rd = AW'(wr);
              exm_wen = fl[0]; mwb_wen = fl[1];
              rf_a = 32'hA000_0000 | rs; rf_b = 32'hB000_0000 | rt;
              #2;
              ea = exp_sel(rs, er, fl[0], wr, fl[1]);
              eb = exp_sel(rt, er, fl[0], wr, fl[1]);
              chk(tag(rs, er, fl[0], wr, fl[1]), {30'd0, sel_a}, {30'd0, ea});
              chk(tag(rt, er, fl[0], wr, fl[1]), {30'd0, sel_b}, {30'd0, eb});
              chk("R9", opnd_a, exp_op(ea, rf_a));
              chk("R9", opnd_b, exp_op(eb, rf_b));
              if (sel_a == 2'b11 || sel_b == 2'b11) chk("R8", {30'd0, sel_a & sel_b}, 32'd0);
              if (rs == rt) begin
                chk("R7", {30'd0, sel_a}, {30'd0, sel_b});
                if (sel_a != 2'b00) chk("R7", opnd_a, opnd_b);
              end
            end
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule